// File: doc/BRIEF.md
# Extended-Period Permuted Congruential Random Source

This block produces 16-bit pseudo-random words. A 32-bit linear congruential state advances on each accepted request. A 16-bit output is taken from the old state with an xorshift followed by a shift that depends on the state's top bits. That output is then XORed with one of eight 16-bit extension words. The updated state's three low bits pick the word.

The eight extension words form one 128-bit counter, with word 0 as the least significant word. Whenever the updated state lands exactly on zero, the counter steps by one. The step is done one word per cycle: word 0 is incremented first, and the next word is touched only while the current one wraps from 0xFFFF to 0. The carry stops at the first word that does not wrap, and a carry out of word 7 is dropped. Because the counter visits every 128-bit pattern, including all zeros, the combined sequence repeats only after 2^160 outputs. Seeding the extension words is therefore optional.

A seed load writes the state and all eight words directly. Each result is announced by a one-cycle valid pulse.

Top module: `pcgx_gen`

## Requirements
- R1: After reset the state is 0, all eight extension words are 0, `rnd` is 0 and `rnd_vld` is 0.
- R2: An accepted request replaces the state S with (S·747796405 + 2891336453) mod 2^32.
- R3: The result of a request is computed in three steps. First, m = S xor (S >> 16), using the old state S. Second, m is shifted right by 13 plus the old state's bits [31:29]. Third, the low 16 bits of that shift are XORed with extension word number (new state bits [2:0]). The word is read as it was before any counter step caused by the same request.
- R4: When the new state equals 0, the extension counter steps by one, one word per cycle. Word 0 is incremented first. The next word is incremented only if the previous one wrapped from 0xFFFF to 0. The carry stops at the first word that does not wrap, and a carry out of word 7 is discarded.
- R5: If no counter step is needed, `rnd_vld` rises in the first cycle after the accepting clock edge. Otherwise it rises after n further edges, where n is the number of words touched (1 to 8). It stays low while the step is in progress.
- R6: A request that arrives while a counter step is in progress is ignored. The state does not advance and the request produces no result.
- R7: A seed load sets the state to `seed_state` and word k to `seed_arr[16k+15:16k]`. It aborts any counter step in progress and clears `rnd_vld`. The next request uses the loaded values.
- R8: When `seed_we` and `req` are high in the same cycle, the load takes effect and the request is ignored.
- R9: `rnd_vld` is high for exactly one cycle per result. `rnd` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_we | input | 1 | Load the seed values this cycle |
| seed_state | input | 32 | State value to load |
| seed_arr | input | 128 | Eight extension words to load, word k at bits [16k+15:16k] |
| req | input | 1 | Request the next value |
| rnd | output | 16 | Latest random word |
| rnd_vld | output | 1 | One-cycle pulse marking a new `rnd` |

## Verification
A wrong state update or a wrong permutation shows up on the very next `rnd` word. A fault in the carry chain is different: it corrupts an extension word silently. It appears at the ports only when a later request's new state selects that word. For this reason the bench follows every counter step with a run of requests, so that several word indices are visited. A miscounted ripple shows up directly as a wrong number of cycles before `rnd_vld` rises.

// File: rtl/pcgx_gen.sv
module pcgx_gen #(
  parameter int SW = 32,
  parameter int OW = 16,
  parameter int NW = 8,
  parameter logic [SW-1:0] MUL = 32'd747796405,
  parameter logic [SW-1:0] INC = 32'd2891336453
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_we,
  input  logic [SW-1:0]   seed_state,
  input  logic [NW*OW-1:0] seed_arr,
  input  logic            req,
  output logic [OW-1:0]   rnd,
  output logic            rnd_vld
);
  localparam int PW   = $clog2(NW);
  localparam int SB   = 3;
  localparam int BASE = SW/2 - SB;

  logic [SW-1:0] st;
  logic [OW-1:0] arr [NW];
  logic          busy;
  logic [PW-1:0] ptr;

  wire          go    = req & ~busy & ~seed_we;
  wire [SW-1:0] st_nx = st * MUL + INC;
  wire [SW-1:0] mix   = st ^ (st >> (SW/2));
  wire [7:0]    sh    = 8'(BASE) + 8'(st[SW-1 -: SB]);
  wire [SW-1:0] shr   = mix >> sh;
  wire [OW-1:0] pick  = arr[st_nx[PW-1:0]];
  wire [OW-1:0] hit   = arr[ptr];
  wire          wrap  = &hit;
  wire          last  = (ptr == PW'(NW-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      busy    <= 1'b0;
      ptr     <= '0;
      rnd     <= '0;
      rnd_vld <= 1'b0;
      for (int k = 0; k < NW; k++) arr[k] <= '0;
    end else begin
      rnd_vld <= 1'b0;
      if (seed_we) begin
        st   <= seed_state;
        busy <= 1'b0;
        ptr  <= '0;
        for (int k = 0; k < NW; k++) arr[k] <= seed_arr[k*OW +: OW];
      end else if (go) begin
        st  <= st_nx;
        rnd <= shr[OW-1:0] ^ pick;
        if (st_nx == '0) begin
          busy <= 1'b1;
          ptr  <= '0;
        end else begin
          rnd_vld <= 1'b1;
        end
      end else if (busy) begin
        arr[ptr] <= hit + 1'b1;
        if (!wrap || last) begin
          busy    <= 1'b0;
          rnd_vld <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcgx_gen_chk.sv
module pcgx_gen_chk #(
  parameter int SW = 32,
  parameter int OW = 16,
  parameter int NW = 8,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_we,
  input logic [SW-1:0] seed_state,
  input logic          req,
  input logic          rnd_vld,
  input logic [SW-1:0] st,
  input logic          busy,
  input logic [PW-1:0] ptr,
  input logic [OW-1:0] hit
);
  p_zero_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> st == '0);
  p_carry_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seed_we && !(&hit)) |=> !busy);
  p_carry_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seed_we && (&hit) && ptr != PW'(NW-1)) |=> (busy && ptr == $past(ptr) + 1'b1));
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rnd_vld);
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && !seed_we) |=> st == $past(st));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> (st == $past(seed_state) && !busy && !rnd_vld));
  p_vld_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_vld |-> ($past(req) || $past(busy)));
endmodule

bind pcgx_gen pcgx_gen_chk #(.SW(SW), .OW(OW), .NW(NW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_state(seed_state),
  .req(req), .rnd_vld(rnd_vld), .st(st), .busy(busy), .ptr(ptr), .hit(hit)
);

// File: tb/sim_pcgx_gen.sv
`timescale 1ns/1ps
module sim_pcgx_gen;
  localparam logic [31:0] MUL = 32'd747796405;
  localparam logic [31:0] INC = 32'd2891336453;

  logic clk = 0, rst_n = 0, seed_we = 0, req = 0;
  logic [31:0] seed_state = '0;
  logic [127:0] seed_arr = '0;
  logic [15:0] rnd;
  logic rnd_vld;
  int checks = 0, errors = 0;

  logic [31:0] m_st;
  logic [15:0] m_arr [8];
  logic [31:0] zpre;

  always #4 clk = ~clk;

  pcgx_gen u0 (.clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_state(seed_state),
               .seed_arr(seed_arr), .req(req), .rnd(rnd), .rnd_vld(rnd_vld));

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] inv32(input logic [31:0] a);
    logic [31:0] x = a;
    for (int i = 0; i < 6; i++) x = x * (32'd2 - a * x);
    return x;
  endfunction

  function automatic logic [15:0] perm(input logic [31:0] s);
    logic [31:0] m = s ^ (s >> 16);
    logic [31:0] r = m >> (13 + s[31:29]);
    return r[15:0];
  endfunction

  // model step: returns expected word and latency
  task automatic model(output logic [15:0] e, output int lat);
    logic [31:0] n = m_st * MUL + INC;
    e = perm(m_st) ^ m_arr[n[2:0]];
    m_st = n;
    lat = 1;
    if (n == 0) begin
      for (int k = 0; k < 8; k++) begin
        m_arr[k] = m_arr[k] + 16'd1;
        lat++;
        if (m_arr[k] != 16'd0) break;
      end
    end
  endtask

  task automatic load(input logic [31:0] s, input logic [127:0] a);
    @(negedge clk);
    seed_we = 1; seed_state = s; seed_arr = a;
    @(negedge clk);
    seed_we = 0;
    m_st = s;
    for (int k = 0; k < 8; k++) m_arr[k] = a[k*16 +: 16];
  endtask

  task automatic do_req(input string rq);
    logic [15:0] e; int el; int lat;
    model(e, el);
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    lat = 1;
    while (!rnd_vld && lat < 20) begin @(negedge clk); lat++; end
    chk(rnd == e, rq, {16'd0, rnd}, {16'd0, e});
    chk(lat == el, {rq, " latency R5"}, lat, el);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rnd == 0 && rnd_vld == 0, "R1 reset outputs", {15'd0, rnd_vld, rnd}, 0);
    m_st = 0;
    for (int k = 0; k < 8; k++) m_arr[k] = 0;
    do_req("R1 first value from reset state");
  endtask

  task automatic t_stream();
    load(32'h1234_5678, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    for (int i = 0; i < 24; i++) do_req("R2 R3 stream");
  endtask

  task automatic t_zero_simple();
    load(zpre, '0);
    do_req("R4 single-word step");
    for (int i = 0; i < 16; i++) do_req("R4 words after step");
  endtask

  task automatic t_ripple();
    load(zpre, {16'h0005, {7{16'hFFFF}}});
    do_req("R4 seven-word ripple");
    for (int i = 0; i < 24; i++) do_req("R4 words after ripple");
  endtask

  task automatic t_wrap_all();
    load(zpre, {8{16'hFFFF}});
    do_req("R4 carry past word 7 dropped");
    for (int i = 0; i < 16; i++) do_req("R4 all-zero array continues");
  endtask

  task automatic t_ignore();
    logic [15:0] e; int el; int lat;
    load(zpre, {96'd0, 16'hFFFF, 16'hFFFF});
    model(e, el);
    @(negedge clk); req = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); req = 0;
    lat = 3;
    while (!rnd_vld && lat < 20) begin @(negedge clk); lat++; end
    chk(rnd == e, "R6 result with held request", {16'd0, rnd}, {16'd0, e});
    chk(lat == el, "R6 latency with held request", lat, el);
    for (int i = 0; i < 8; i++) do_req("R6 state not advanced during step");
  endtask

  task automatic t_priority();
    @(negedge clk);
    seed_we = 1; req = 1; seed_state = 32'hCAFE_0001; seed_arr = {8{16'h5A5A}};
    @(negedge clk);
    seed_we = 0; req = 0;
    chk(rnd_vld == 0, "R8 request ignored under load", rnd_vld, 0);
    m_st = 32'hCAFE_0001;
    for (int k = 0; k < 8; k++) m_arr[k] = 16'h5A5A;
    do_req("R8 loaded state used");
  endtask

  task automatic t_abort();
    int seen = 0;
    load(zpre, {8{16'hFFFF}});
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    @(negedge clk); seed_we = 1; seed_state = 32'h0BAD_F00D; seed_arr = {8{16'h1234}};
    @(negedge clk); seed_we = 0;
    for (int i = 0; i < 10; i++) begin
      if (rnd_vld) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R7 aborted step gives no result", seen, 0);
    m_st = 32'h0BAD_F00D;
    for (int k = 0; k < 8; k++) m_arr[k] = 16'h1234;
    for (int i = 0; i < 6; i++) do_req("R7 loaded values after abort");
  endtask

  task automatic t_hold();
    logic [15:0] held;
    do_req("R9 result");
    held = rnd;
    @(negedge clk);
    chk(rnd_vld == 0, "R9 single-cycle pulse", rnd_vld, 0);
    repeat (4) @(negedge clk);
    chk(rnd == held && rnd_vld == 0, "R9 output held", {15'd0, rnd_vld, rnd}, {16'd0, held});
  endtask

  initial begin
    zpre = (32'd0 - INC) * inv32(MUL);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stream();
    t_zero_simple();
    t_ripple();
    t_wrap_all();
    t_ignore();
    t_priority();
    t_abort();
    t_hold();
    summary();
  end
endmodule